// File: doc/BRIEF.md
# Aliased Register File Views

This block holds a general-purpose register file of 32 entries of 64 bits and lets the surrounding datapath reach that one storage through four views. Each access carries a two-bit view code. The full-width view addresses the entries directly. In this view, index 31 is a hard zero: reads return 0 and writes are dropped. The half-width view exposes bits 31..0 of the full-width view and shares its hard-zero index. Two single-register views always reach the physical entries behind the aliases, regardless of the index presented: the stack-pointer view reaches entry 31 and the link-register view reaches entry 30.

There are two combinational read ports and one write port, which takes effect on the rising clock edge. A parameter decides how a half-width write fills bits 63..32 of its entry. It can clear them, copy bit 31 into them, or keep their old contents. Reset is synchronous and active low, and it clears every entry.

Top module: `regfile_views`

## Requirements
- R1: While `rst_n` is low at a rising edge, every entry becomes 0. After reset, every view on both read ports returns 0 until the next write.
- R2: With view code 0 (full width) and index 31, a read port returns 0 whatever entry 31 holds.
- R3: A write with view code 0 or 1 to index 31 changes no entry. The stack-pointer view still returns the old entry-31 value afterwards.
- R4: With view code 1 (half width), a read returns bits 31..0 of the addressed entry in data bits 31..0, with bits 63..32 at 0. Index 31 reads 0.
- R5: View code 2 (stack pointer) ignores the index. It reads entry 31, and a write with it stores all 64 data bits into entry 31.
- R6: View code 3 (link register) ignores the index. It reads and writes entry 30, and the full view at index 30 shows the same value.
- R7: With `FILL_MODE` = 0 (zero fill, the default), a half-width write stores data bits 31..0 and clears bits 63..32 of the entry.
- R8: With `FILL_MODE` = 1 (sign fill), a half-width write stores data bits 31..0 and copies data bit 31 into bits 63..32.
- R9: With `FILL_MODE` = 2 (merge), a half-width write stores data bits 31..0 and leaves bits 63..32 of the entry unchanged.
- R10: A read of an entry in the same cycle as a write to it returns the value from before the write.
- R11: A full-width write to an index below 31 stores all 64 bits at the rising edge. The value is visible on the read ports right after that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| rd_a_view | input | 2 | View code of read port A (0 full, 1 half, 2 stack pointer, 3 link register) |
| rd_a_idx | input | 5 | Entry index of read port A |
| rd_a_data | output | 64 | Read data of port A, combinational |
| rd_b_view | input | 2 | View code of read port B |
| rd_b_idx | input | 5 | Entry index of read port B |
| rd_b_data | output | 64 | Read data of port B, combinational |
| wr_en | input | 1 | Write enable |
| wr_view | input | 2 | View code of the write |
| wr_idx | input | 5 | Entry index of the write |
| wr_data | input | 64 | Write data (bits 31..0 only for a half-width write) |

## Verification
Read data follows the stored entries and the read inputs without any register, so it is due in the same cycle as the read inputs. A write changes storage at the next rising edge, and its effect is due on the read ports right after that edge. The bench drives each cycle's inputs at the falling edge and compares both read ports shortly afterwards, while the write of that cycle is still pending. It then advances its own model at the rising edge. This way every same-cycle read sees the old value, and every later read sees the new one. Three instances, one per fill mode, get the same stimulus so that the fill behaviour is compared side by side.

// File: rtl/rfv_pkg.sv
// Package: shared view codes and fill-mode constants for the aliased register file.
// Assumes: a two-bit view code on every access port.
package rfv_pkg;
    typedef enum logic [1:0] {
        VIEW_FULL = 2'd0,
        VIEW_HALF = 2'd1,
        VIEW_SP   = 2'd2,
        VIEW_LR   = 2'd3
    } view_e;

    localparam int FILL_ZERO  = 0;
    localparam int FILL_SIGN  = 1;
    localparam int FILL_MERGE = 2;
endpackage

// File: rtl/rfv_store.sv
// Module: rfv_store - the physical entry array with one write port.
// Assumes: the write request has already been shaped by the view logic;
// a request with we low never touches storage. Reset is synchronous, active low.
module rfv_store #(
    parameter int NUM_REGS = 32,
    parameter int DATA_W   = 64,
    localparam int IDX_W   = $clog2(NUM_REGS)
) (
    input  logic                             clk,
    input  logic                             rst_n,
    input  logic                             we,
    input  logic [IDX_W-1:0]                 widx,
    input  logic [DATA_W-1:0]                wval,
    output logic [NUM_REGS-1:0][DATA_W-1:0]  mem_q
);
    // Storage update: clear on reset, otherwise commit the shaped write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mem_q <= '0;
        end else if (we) begin
            mem_q[widx] <= wval;
        end
    end
endmodule

// File: rtl/rfv_read_port.sv
// Module: rfv_read_port - turns a view code and an index into read data.
// Assumes: entry ZERO_IDX is masked as a hard zero in the full and half views only;
// the dedicated views ignore the index and reach their fixed entries.
module rfv_read_port #(
    parameter int NUM_REGS = 32,
    parameter int DATA_W   = 64,
    parameter int HALF_W   = 32,
    parameter int ZERO_IDX = 31,
    parameter int SP_IDX   = 31,
    parameter int LR_IDX   = 30,
    localparam int IDX_W   = $clog2(NUM_REGS)
) (
    input  logic [NUM_REGS-1:0][DATA_W-1:0]  mem_q,
    input  rfv_pkg::view_e                   view,
    input  logic [IDX_W-1:0]                 idx,
    output logic [DATA_W-1:0]                data
);
    import rfv_pkg::*;

    logic             is_zero_idx;
    logic [DATA_W-1:0] raw;

    assign is_zero_idx = (idx == IDX_W'(ZERO_IDX));
    assign raw         = mem_q[idx];

    // View decode: pick the entry, then apply the zero mask or the half-width window.
    always_comb begin
        unique case (view)
            VIEW_FULL: data = is_zero_idx ? '0 : raw;
            VIEW_HALF: data = is_zero_idx ? '0 : {{(DATA_W-HALF_W){1'b0}}, raw[HALF_W-1:0]};
            VIEW_SP:   data = mem_q[SP_IDX];
            VIEW_LR:   data = mem_q[LR_IDX];
            default:   data = '0;
        endcase
    end
endmodule

// File: rtl/rfv_write_shaper.sv
// Module: rfv_write_shaper - maps a view write onto a physical entry and value.
// Assumes: old_val is the current content of entry idx; FILL_MODE picks how a
// half-width write fills the upper bits (0 zero, 1 sign, 2 keep old).
module rfv_write_shaper #(
    parameter int NUM_REGS  = 32,
    parameter int DATA_W    = 64,
    parameter int HALF_W    = 32,
    parameter int FILL_MODE = 0,
    parameter int ZERO_IDX  = 31,
    parameter int SP_IDX    = 31,
    parameter int LR_IDX    = 30,
    localparam int IDX_W    = $clog2(NUM_REGS),
    localparam int UP_W     = DATA_W - HALF_W
) (
    input  logic                wr_en,
    input  rfv_pkg::view_e      view,
    input  logic [IDX_W-1:0]    idx,
    input  logic [DATA_W-1:0]   wdata,
    input  logic [DATA_W-1:0]   old_val,
    output logic                we,
    output logic [IDX_W-1:0]    widx,
    output logic [DATA_W-1:0]   wval
);
    import rfv_pkg::*;

    localparam logic [DATA_W-1:0] KEEP_MASK =
        (FILL_MODE == FILL_MERGE) ? {{UP_W{1'b1}}, {HALF_W{1'b0}}} : '0;
    localparam bit SIGN_FILL = (FILL_MODE == FILL_SIGN);

    logic [DATA_W-1:0] ext_val;
    logic [DATA_W-1:0] half_val;
    logic              is_zero_idx;

    generate
        if (FILL_MODE < FILL_ZERO || FILL_MODE > FILL_MERGE) begin : g_bad_fill
            $error("rfv_write_shaper: FILL_MODE must be 0, 1 or 2");
        end
    endgenerate

    assign is_zero_idx = (idx == IDX_W'(ZERO_IDX));
    assign ext_val     = {{UP_W{SIGN_FILL & wdata[HALF_W-1]}}, wdata[HALF_W-1:0]};
    assign half_val    = (old_val & KEEP_MASK) | (ext_val & ~KEEP_MASK);

    // Write mapping: choose the physical entry, the value, and drop hard-zero targets.
    always_comb begin
        we   = 1'b0;
        widx = idx;
        wval = wdata;
        unique case (view)
            VIEW_FULL: we = wr_en & ~is_zero_idx;
            VIEW_HALF: begin
                we   = wr_en & ~is_zero_idx;
                wval = half_val;
            end
            VIEW_SP: begin
                we   = wr_en;
                widx = IDX_W'(SP_IDX);
            end
            VIEW_LR: begin
                we   = wr_en;
                widx = IDX_W'(LR_IDX);
            end
            default: we = 1'b0;
        endcase
    end
endmodule

// File: rtl/regfile_views.sv
// Module: regfile_views - 32x64 register file reached through full, half,
// stack-pointer and link-register views; two combinational reads, one clocked write.
// Assumes: view slices start at bit 0 (HALF_LSB must be 0); reads see storage
// before the same-cycle write; synchronous active-low reset clears all entries.
module regfile_views #(
    parameter int NUM_REGS  = 32,
    parameter int DATA_W    = 64,
    parameter int HALF_W    = 32,
    parameter int HALF_LSB  = 0,
    parameter int FILL_MODE = 0,
    localparam int IDX_W    = $clog2(NUM_REGS),
    localparam int ZERO_IDX = NUM_REGS - 1,
    localparam int SP_IDX   = NUM_REGS - 1,
    localparam int LR_IDX   = NUM_REGS - 2,
    localparam int NUM_RD   = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0]        rd_a_view,
    input  logic [IDX_W-1:0]  rd_a_idx,
    output logic [DATA_W-1:0] rd_a_data,
    input  logic [1:0]        rd_b_view,
    input  logic [IDX_W-1:0]  rd_b_idx,
    output logic [DATA_W-1:0] rd_b_data,
    input  logic              wr_en,
    input  logic [1:0]        wr_view,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [DATA_W-1:0] wr_data
);
    import rfv_pkg::*;

    logic [NUM_REGS-1:0][DATA_W-1:0] mem_q;
    logic                            st_we;
    logic [IDX_W-1:0]                st_widx;
    logic [DATA_W-1:0]               st_wval;
    view_e                           rd_view [NUM_RD];
    logic [IDX_W-1:0]                rd_idx  [NUM_RD];
    logic [DATA_W-1:0]               rd_data [NUM_RD];

    generate
        if (HALF_LSB != 0) begin : g_bad_slice
            $error("regfile_views: half-width slice must start at bit 0");
        end
    endgenerate

    assign rd_view[0] = view_e'(rd_a_view);
    assign rd_idx[0]  = rd_a_idx;
    assign rd_view[1] = view_e'(rd_b_view);
    assign rd_idx[1]  = rd_b_idx;
    assign rd_a_data  = rd_data[0];
    assign rd_b_data  = rd_data[1];

    rfv_write_shaper #(
        .NUM_REGS(NUM_REGS), .DATA_W(DATA_W), .HALF_W(HALF_W), .FILL_MODE(FILL_MODE),
        .ZERO_IDX(ZERO_IDX), .SP_IDX(SP_IDX), .LR_IDX(LR_IDX)
    ) u_shaper (
        .wr_en  (wr_en),
        .view   (view_e'(wr_view)),
        .idx    (wr_idx),
        .wdata  (wr_data),
        .old_val(mem_q[wr_idx]),
        .we     (st_we),
        .widx   (st_widx),
        .wval   (st_wval)
    );

    rfv_store #(.NUM_REGS(NUM_REGS), .DATA_W(DATA_W)) u_store (
        .clk  (clk),
        .rst_n(rst_n),
        .we   (st_we),
        .widx (st_widx),
        .wval (st_wval),
        .mem_q(mem_q)
    );

    generate
        for (genvar p = 0; p < NUM_RD; p++) begin : g_rd
            rfv_read_port #(
                .NUM_REGS(NUM_REGS), .DATA_W(DATA_W), .HALF_W(HALF_W),
                .ZERO_IDX(ZERO_IDX), .SP_IDX(SP_IDX), .LR_IDX(LR_IDX)
            ) u_rd (
                .mem_q(mem_q),
                .view (rd_view[p]),
                .idx  (rd_idx[p]),
                .data (rd_data[p])
            );
        end
    endgenerate

    // Reset clears every entry.
    p_reset_clears_r1: assert property (@(posedge clk) !rst_n |=> mem_q == '0);

    // Full view at the zero index always reads zero.
    p_zero_read_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_a_view == 2'd0 && rd_a_idx == IDX_W'(ZERO_IDX)) |-> rd_a_data == '0);

    // Full or half write at the zero index leaves the stack-pointer entry alone.
    p_zero_discard_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !wr_view[1] && wr_idx == IDX_W'(ZERO_IDX)) |=> $stable(mem_q[SP_IDX]));

    // Half view never drives the upper data bits.
    p_half_upper_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_b_view == 2'd1) |-> rd_b_data[DATA_W-1:HALF_W] == '0);

    // Stack-pointer write stores the whole word in its entry.
    p_sp_write_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_view == 2'd2) |=> mem_q[SP_IDX] == $past(wr_data));

    // Link-register write stores the whole word in its entry.
    p_lr_write_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_view == 2'd3) |=> mem_q[LR_IDX] == $past(wr_data));

    generate
        if (FILL_MODE == FILL_ZERO) begin : g_chk_zero
            // Zero fill clears the upper bits.
            p_fill_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
                (wr_en && wr_view == 2'd1 && wr_idx != IDX_W'(ZERO_IDX))
                |=> mem_q[$past(wr_idx)][DATA_W-1:HALF_W] == '0);
        end else if (FILL_MODE == FILL_SIGN) begin : g_chk_sign
            // Sign fill copies the written bit 31 upward.
            p_fill_sign_r8: assert property (@(posedge clk) disable iff (!rst_n)
                (wr_en && wr_view == 2'd1 && wr_idx != IDX_W'(ZERO_IDX))
                |=> mem_q[$past(wr_idx)][DATA_W-1:HALF_W]
                    == {(DATA_W-HALF_W){$past(wr_data[HALF_W-1])}});
        end else begin : g_chk_merge
            // Merge keeps the old upper bits.
            p_fill_merge_r9: assert property (@(posedge clk) disable iff (!rst_n)
                (wr_en && wr_view == 2'd1 && wr_idx != IDX_W'(ZERO_IDX))
                |=> mem_q[$past(wr_idx)][DATA_W-1:HALF_W]
                    == $past(mem_q[wr_idx][DATA_W-1:HALF_W]));
        end
    endgenerate

    // Full write below the zero index lands intact.
    p_full_write_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_view == 2'd0 && wr_idx != IDX_W'(ZERO_IDX))
        |=> mem_q[$past(wr_idx)] == $past(wr_data));
endmodule

// File: tb/test_regfile_views.sv
// Bench: three instances (zero, sign, merge fill) on one stimulus, checked every
// cycle against a behavioural model of the views.
module test_regfile_views;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  va = 2'd0, vb = 2'd0, wv = 2'd0;
    logic [4:0]  ia = 5'd0, ib = 5'd0, wi = 5'd0;
    logic        we = 1'b0;
    logic [63:0] wd = '0;
    logic [63:0] rda [3];
    logic [63:0] rdb [3];

    logic [63:0] mdl   [3][32];
    bit          halfw [3][32];
    bit          discard_seen = 1'b0;
    int          since_rst = 0;
    int          total = 0;
    int          bad = 0;
    bit          finished = 1'b0;

    always #10 clk = ~clk;

    regfile_views #(.FILL_MODE(0)) i_regfile_views (
        .clk(clk), .rst_n(rst_n),
        .rd_a_view(va), .rd_a_idx(ia), .rd_a_data(rda[0]),
        .rd_b_view(vb), .rd_b_idx(ib), .rd_b_data(rdb[0]),
        .wr_en(we), .wr_view(wv), .wr_idx(wi), .wr_data(wd));

    regfile_views #(.FILL_MODE(1)) i_regfile_views_sign (
        .clk(clk), .rst_n(rst_n),
        .rd_a_view(va), .rd_a_idx(ia), .rd_a_data(rda[1]),
        .rd_b_view(vb), .rd_b_idx(ib), .rd_b_data(rdb[1]),
        .wr_en(we), .wr_view(wv), .wr_idx(wi), .wr_data(wd));

    regfile_views #(.FILL_MODE(2)) i_regfile_views_merge (
        .clk(clk), .rst_n(rst_n),
        .rd_a_view(va), .rd_a_idx(ia), .rd_a_data(rda[2]),
        .rd_b_view(vb), .rd_b_idx(ib), .rd_b_data(rdb[2]),
        .wr_en(we), .wr_view(wv), .wr_idx(wi), .wr_data(wd));

    function automatic logic [63:0] model_read(int k, logic [1:0] v, logic [4:0] i);
        case (v)
            2'd0:    return (i == 5'd31) ? 64'd0 : mdl[k][i];
            2'd1:    return (i == 5'd31) ? 64'd0 : {32'd0, mdl[k][i][31:0]};
            2'd2:    return mdl[k][31];
            default: return mdl[k][30];
        endcase
    endfunction

    function automatic int phys(logic [1:0] v, logic [4:0] i);
        if (v == 2'd2) return 31;
        if (v == 2'd3) return 30;
        return int'(i);
    endfunction

    function automatic string tag_for(int k, logic [1:0] v, logic [4:0] i);
        if (since_rst == 0) return "R1";
        if (v == 2'd0 && i == 5'd31) return "R2";
        if (v == 2'd1) return "R4";
        if (v == 2'd2) return discard_seen ? "R3" : "R5";
        if (v == 2'd3) return "R6";
        if (we && phys(wv, wi) == int'(i) && !(wv[1] == 1'b0 && wi == 5'd31)) return "R10";
        if (halfw[k][i]) return (k == 0) ? "R7" : (k == 1) ? "R8" : "R9";
        return "R11";
    endfunction

    task automatic check(string tag, int k, string port, logic [63:0] act, logic [63:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s inst=%0d port=%s actual=%h expected=%h", tag, k, port, act, exp);
        end
    endtask

    task automatic model_write();
        for (int k = 0; k < 3; k++) begin
            if (we) begin
                case (wv)
                    2'd0: if (wi != 5'd31) begin mdl[k][wi] = wd; halfw[k][wi] = 1'b0; end
                    2'd1: if (wi != 5'd31) begin
                        case (k)
                            0: mdl[k][wi] = {32'd0, wd[31:0]};
                            1: mdl[k][wi] = {{32{wd[31]}}, wd[31:0]};
                            default: mdl[k][wi] = {mdl[k][wi][63:32], wd[31:0]};
                        endcase
                        halfw[k][wi] = 1'b1;
                    end
                    2'd2: begin mdl[k][31] = wd; halfw[k][31] = 1'b0; end
                    default: begin mdl[k][30] = wd; halfw[k][30] = 1'b0; end
                endcase
            end
        end
        if (we && wv[1] == 1'b0 && wi == 5'd31) discard_seen = 1'b1;
        if (we && wv == 2'd2) discard_seen = 1'b0;
    endtask

    task automatic step(input logic [1:0] a_v, input logic [4:0] a_i,
                        input logic [1:0] b_v, input logic [4:0] b_i,
                        input logic w_e, input logic [1:0] w_v,
                        input logic [4:0] w_i, input logic [63:0] w_d);
        @(negedge clk);
        va = a_v; ia = a_i; vb = b_v; ib = b_i;
        we = w_e; wv = w_v; wi = w_i; wd = w_d;
        #1;
        for (int k = 0; k < 3; k++) begin
            check(tag_for(k, va, ia), k, "A", rda[k], model_read(k, va, ia));
            check(tag_for(k, vb, ib), k, "B", rdb[k], model_read(k, vb, ib));
        end
        @(posedge clk);
        model_write();
        since_rst++;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        we = 1'b0;
        @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        for (int k = 0; k < 3; k++)
            for (int e = 0; e < 32; e++) begin
                mdl[k][e] = '0;
                halfw[k][e] = 1'b0;
            end
        discard_seen = 1'b0;
        since_rst = 0;
    endtask

    initial begin
        #(20 * 200000);
        if (!finished) begin
            bad++;
            total++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        do_reset();
        // R1: all views read zero after reset
        step(2'd2, 5'd0, 2'd3, 5'd0, 1'b0, 2'd0, 5'd0, '0);
        step(2'd0, 5'd7, 2'd1, 5'd7, 1'b1, 2'd2, 5'd3, 64'hDEAD_BEEF_0123_4567);
        // R5 then R3: full and half writes to index 31 are dropped
        step(2'd2, 5'd9, 2'd0, 5'd31, 1'b1, 2'd0, 5'd31, 64'h1111_2222_3333_4444);
        step(2'd2, 5'd0, 2'd0, 5'd31, 1'b1, 2'd1, 5'd31, 64'h5555_6666_7777_8888);
        step(2'd2, 5'd0, 2'd1, 5'd31, 1'b0, 2'd0, 5'd0, '0);
        // R6: link register and full view at 30 agree
        step(2'd3, 5'd1, 2'd0, 5'd30, 1'b1, 2'd3, 5'd12, 64'hCAFE_F00D_8000_0001);
        step(2'd3, 5'd1, 2'd0, 5'd30, 1'b0, 2'd0, 5'd0, '0);
        // R11 and R10: full write, same-cycle read sees old value
        step(2'd0, 5'd5, 2'd1, 5'd5, 1'b1, 2'd0, 5'd5, 64'hAAAA_BBBB_8765_4321);
        step(2'd0, 5'd5, 2'd1, 5'd5, 1'b1, 2'd1, 5'd5, 64'h0000_0000_F000_0001);
        // R7 R8 R9: fill policy with bit 31 set, then clear
        step(2'd0, 5'd5, 2'd1, 5'd5, 1'b1, 2'd1, 5'd5, 64'hFFFF_FFFF_1234_5678);
        step(2'd0, 5'd5, 2'd0, 5'd6, 1'b0, 2'd0, 5'd0, '0);
        for (int n = 0; n < 600; n++) begin
            step(2'($urandom), 5'($urandom), 2'($urandom), 5'($urandom),
                 1'($urandom), 2'($urandom), 5'($urandom), {$urandom, $urandom});
        end
        do_reset();
        step(2'd0, 5'd5, 2'd3, 5'd0, 1'b0, 2'd0, 5'd0, '0);
        step(2'd2, 5'd0, 2'd1, 5'd9, 1'b0, 2'd0, 5'd0, '0);
        finished = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule